// File: doc/BRIEF.md
# Nested Loop Down-Counter with Count Stack

This block holds the iteration count of the innermost active loop in a program sequencer. It has a 14-bit down-counter and a 4-entry last-in-first-out stack that keeps the counts of the outer loops while an inner loop runs. The counter is loaded from a 16-bit data bus. Its value is always visible on a 16-bit read port, with the two upper bits at zero. The block also drives a counter-expired status, `ceOut`, which the sequencer samples when it tests the loop condition.

A normal load saves the current count on the stack before it writes the new one. It skips the save when the counter holds no valid value, so that no stack slot is spent on a meaningless count. An overwrite load replaces the count and never saves it. A test request carries a flag that says whether the instruction doing the test may decrement the counter. A test that finds the counter expired restores the outer count from the stack, or marks the counter invalid when the stack is empty. A manual pop serves early loop exits. The block reports a stack-empty status and a sticky stack-overflow status.

Top module: `loop_count_unit`

## Requirements
- R1: After reset, `rdData` is 0, `stackEmpty` is 1, `stackOvf` is 0, `ceOut` is 0, and the counter is invalid.
- R2: `rdData` always shows the current count in bits 13:0, and bits 15:14 are always 0. Reading has no effect on the count. A load takes only `wrData[13:0]`.
- R3: A normal load (`wrEn`) writes `wrData[13:0]` into the counter and marks it valid. When the counter was valid and the stack was not full, the old count is pushed onto the stack in the same cycle.
- R4: A normal load while the counter is invalid pushes nothing.
- R5: An overwrite load (`owrEn`) writes `wrData[13:0]` into the counter and marks it valid. It never pushes.
- R6: `ceOut` is 1 exactly when the counter is valid and its value equals 1.
- R7: A test (`testEn`) with `ceOut` = 0 decrements the counter by one when `testDec` = 1 (jump-type test). When `testDec` = 0 (return-type or arithmetic-type test), the counter is unchanged. A test on an invalid counter changes nothing.
- R8: A test with `ceOut` = 1 pops the stack top into the counter, whatever `testDec` is. If the stack is empty, the counter becomes invalid instead and keeps its value.
- R9: A manual pop (`popEn`) on a non-empty stack moves the top entry into the counter and marks it valid. On an empty stack it changes nothing.
- R10: A push requested while the stack already holds 4 entries sets `stackOvf`, discards the pushed value and still performs the load. `stackOvf` stays 1 until reset.
- R11: Only one request acts per cycle, with priority `wrEn` > `owrEn` > `testEn` > `popEn`.
- R12: `stackEmpty` is 1 exactly when the stack holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Normal load request (saves the old count) |
| owrEn | input | 1 | Overwrite load request (no save) |
| wrData | input | 16 | Load data bus |
| testEn | input | 1 | Counter-expired test request |
| testDec | input | 1 | Test may decrement (jump-type test) |
| popEn | input | 1 | Manual stack pop request |
| rdData | output | 16 | Current count, upper two bits zero |
| ceOut | output | 1 | Counter expired (valid and count is 1) |
| stackEmpty | output | 1 | Count stack holds no entries |
| stackOvf | output | 1 | Sticky: a push hit a full stack |

## Verification
The valid flag and the stack pointer cannot be seen directly. A wrong stack pointer shows at the ports on the first expiring test or manual pop after the fault: `rdData` then returns the wrong outer count, or `stackEmpty` takes the wrong value in the same cycle. A wrong valid flag shows at once on `ceOut` when the count is 1. When the count is not 1, it shows one load later as a missing or extra push, which `stackEmpty` reveals. The bench therefore follows every load and test with a check of all four outputs in the cycle after the clock edge. It also runs the stack down to empty after an overflow, so that a discarded or misplaced entry appears in `rdData`.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  // Strobes from control to datapath; at most one of loadCnt/decCnt/popToCnt per cycle.
  typedef struct packed {
    logic loadCnt;   // counter <= bus data
    logic decCnt;    // counter <= counter - 1
    logic popToCnt;  // counter <= stack top, pointer down
    logic pushCnt;   // stack top <= counter, pointer up
    logic setOvf;    // sticky overflow set
  } lcu_strobe_t;
endpackage

// File: rtl/lcu_ctrl.sv
module lcu_ctrl
  import lcu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        owrEn,
  input  logic        testEn,
  input  logic        testDec,
  input  logic        popEn,
  input  logic        cntIsOne,
  input  logic        stkEmpty,
  input  logic        stkFull,
  output lcu_strobe_t strb,
  output logic        cntValid,
  output logic        ceOut
);
  logic nextValid;

  assign ceOut = cntValid & cntIsOne;

  always_comb begin
    strb      = '0;
    nextValid = cntValid;
    if (wrEn) begin
      strb.loadCnt = 1'b1;
      nextValid    = 1'b1;
      if (cntValid) begin
        if (stkFull) strb.setOvf  = 1'b1;
        else         strb.pushCnt = 1'b1;
      end
    end else if (owrEn) begin
      strb.loadCnt = 1'b1;
      nextValid    = 1'b1;
    end else if (testEn) begin
      if (cntValid) begin
        if (ceOut) begin
          if (!stkEmpty) strb.popToCnt = 1'b1;
          else           nextValid     = 1'b0;
        end else if (testDec) begin
          strb.decCnt = 1'b1;
        end
      end
    end else if (popEn && !stkEmpty) begin
      strb.popToCnt = 1'b1;
      nextValid     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cntValid <= 1'b0;
    else        cntValid <= nextValid;
  end

  // R11: a single counter update per cycle
  a_r11_one_update: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadCnt, strb.decCnt, strb.popToCnt}));

  // R8: expiring test on an empty stack leaves the counter invalid
  a_r8_expire_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (testEn && !wrEn && !owrEn && ceOut && stkEmpty) |=> !cntValid);

  // R4: no push from an invalid counter
  a_r4_no_push_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !cntValid |-> !strb.pushCnt);

  // R5: overwrite path never pushes
  a_r5_owr_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (owrEn && !wrEn) |-> !strb.pushCnt);
endmodule

// File: rtl/lcu_datapath.sv
module lcu_datapath
  import lcu_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  lcu_strobe_t      strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             cntIsOne,
  output logic             stkEmpty,
  output logic             stkFull,
  output logic             stackOvf
);
  logic [CNT_W-1:0] stk [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] stkTop;

  assign stkEmpty = (ptr == '0);
  assign stkFull  = (ptr == PTR_W'(DEPTH));
  assign stkTop   = stkEmpty ? '0 : stk[ptr - PTR_W'(1)];
  assign cntIsOne = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (strb.loadCnt)   cnt <= loadVal;
    else if (strb.popToCnt)  cnt <= stkTop;
    else if (strb.decCnt)    cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ptr <= '0;
    else if (strb.pushCnt && !stkFull)     ptr <= ptr + PTR_W'(1);
    else if (strb.popToCnt && !stkEmpty)   ptr <= ptr - PTR_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 stk[i] <= '0;
      else if (strb.pushCnt && ptr == PTR_W'(i))  stk[i] <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stackOvf <= 1'b0;
    else if (strb.setOvf) stackOvf <= 1'b1;
  end

  // R10: overflow is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stackOvf |=> stackOvf);

  // R3: a push grows the stack by one
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pushCnt |=> ptr == $past(ptr) + PTR_W'(1));

  // R7: a decrement lowers the count by one
  a_r7_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    strb.decCnt |=> cnt == $past(cnt) - CNT_W'(1));

  // R9: a pop delivers the previous top entry
  a_r9_pop_value: assert property (@(posedge clk) disable iff (!rst_n)
    strb.popToCnt |=> cnt == $past(stkTop));

  // R12: pointer never exceeds the depth
  a_r12_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(DEPTH));
endmodule

// File: rtl/loop_count_unit.sv
module loop_count_unit
  import lcu_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int BUS_W = 16,
  parameter int DEPTH = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             owrEn,
  input  logic [BUS_W-1:0] wrData,
  input  logic             testEn,
  input  logic             testDec,
  input  logic             popEn,
  output logic [BUS_W-1:0] rdData,
  output logic             ceOut,
  output logic             stackEmpty,
  output logic             stackOvf
);
  lcu_strobe_t      strb;
  logic [CNT_W-1:0] cnt;
  logic             cntIsOne, stkFull, cntValid;

  lcu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .owrEn(owrEn), .testEn(testEn),
    .testDec(testDec), .popEn(popEn), .cntIsOne(cntIsOne),
    .stkEmpty(stackEmpty), .stkFull(stkFull), .strb(strb),
    .cntValid(cntValid), .ceOut(ceOut)
  );

  lcu_datapath #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadVal(wrData[CNT_W-1:0]),
    .cnt(cnt), .cntIsOne(cntIsOne), .stkEmpty(stackEmpty),
    .stkFull(stkFull), .stackOvf(stackOvf)
  );

  assign rdData = {{(BUS_W-CNT_W){1'b0}}, cnt};

  // R6: expiry reported only for a valid counter
  a_r6_ce_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ceOut |-> cntValid);
endmodule

// File: tb/tb_loop_count_unit.sv
module tb_loop_count_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wrEn, owrEn, testEn, testDec, popEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        ceOut, stackEmpty, stackOvf;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  loop_count_unit dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .owrEn(owrEn), .wrData(wrData),
    .testEn(testEn), .testDec(testDec), .popEn(popEn), .rdData(rdData),
    .ceOut(ceOut), .stackEmpty(stackEmpty), .stackOvf(stackOvf)
  );

  // op codes: 0 idle, 1 load, 2 overwrite, 3 test+dec, 4 test no dec, 5 pop
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic [15:0] expRd;
    logic        expEmpty;
    logic        expCe;
    logic        expOvf;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 16'd3,      16'd3,      1'b1, 1'b0, 1'b0}, // R4 load while invalid
    '{3'd1, 16'd2,      16'd2,      1'b0, 1'b0, 1'b0}, // R3 load pushes 3
    '{3'd3, 16'd0,      16'd1,      1'b0, 1'b1, 1'b0}, // R7 dec to 1, R6
    '{3'd4, 16'd0,      16'd3,      1'b1, 1'b0, 1'b0}, // R8 expire pops 3
    '{3'd4, 16'd0,      16'd3,      1'b1, 1'b0, 1'b0}, // R7 no-dec test
    '{3'd3, 16'd0,      16'd2,      1'b1, 1'b0, 1'b0}, // R7
    '{3'd3, 16'd0,      16'd1,      1'b1, 1'b1, 1'b0}, // R7 R6
    '{3'd3, 16'd0,      16'd1,      1'b1, 1'b0, 1'b0}, // R8 empty -> invalid
    '{3'd3, 16'd0,      16'd1,      1'b1, 1'b0, 1'b0}, // R7 invalid test no effect
    '{3'd1, 16'd5,      16'd5,      1'b1, 1'b0, 1'b0}, // R4 no push after invalid
    '{3'd2, 16'd1,      16'd1,      1'b1, 1'b1, 1'b0}, // R5 overwrite, no push
    '{3'd1, 16'hFFFF,   16'h3FFF,   1'b0, 1'b0, 1'b0}, // R2 upper bits dropped
    '{3'd5, 16'd0,      16'd1,      1'b1, 1'b1, 1'b0}, // R9 pop restores 1
    '{3'd5, 16'd0,      16'd1,      1'b1, 1'b1, 1'b0}  // R9 pop on empty
  };

  task automatic idleIn();
    wrEn = 0; owrEn = 0; testEn = 0; testDec = 0; popEn = 0; wrData = '0;
  endtask

  task automatic chk(string tag, logic [15:0] rd, logic em, logic ce, logic ov);
    nChecks++;
    if (rdData !== rd || stackEmpty !== em || ceOut !== ce || stackOvf !== ov) begin
      nFails++;
      $display("FAIL %s: rd=%h empty=%b ce=%b ovf=%b expected rd=%h empty=%b ce=%b ovf=%b",
               tag, rdData, stackEmpty, ceOut, stackOvf, rd, em, ce, ov);
    end
  endtask

  // drive at negedge, one posedge, sample 1ns later
  task automatic step(logic [2:0] op, logic [15:0] d);
    @(negedge clk);
    idleIn();
    wrData = d;
    case (op)
      3'd1: wrEn = 1;
      3'd2: owrEn = 1;
      3'd3: begin testEn = 1; testDec = 1; end
      3'd4: testEn = 1;
      3'd5: popEn = 1;
      default: ;
    endcase
    @(posedge clk);
    #1;
    idleIn();
  endtask

  task automatic doReset();
    idleIn();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    chk("R1 reset", 16'd0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].data);
      chk($sformatf("vector %0d (R2-R9)", i), VECS[i].expRd,
          VECS[i].expEmpty, VECS[i].expCe, VECS[i].expOvf);
    end

    // R10: fill the stack, overflow, then drain it
    doReset();
    for (int v = 10; v <= 14; v++) step(3'd1, 16'(v));
    chk("R10 full", 16'd14, 1'b0, 1'b0, 1'b0);
    step(3'd1, 16'd15);
    chk("R10 overflow set", 16'd15, 1'b0, 1'b0, 1'b1);
    for (int v = 13; v >= 10; v--) begin
      step(3'd5, 16'd0);
      chk("R10 R12 drain", 16'(v), (v == 10), 1'b0, 1'b1);
    end
    step(3'd5, 16'd0);
    chk("R9 R10 empty pop, ovf sticky", 16'd10, 1'b1, 1'b0, 1'b1);

    // R11: priority between simultaneous requests
    doReset();
    step(3'd1, 16'd10);
    @(negedge clk);
    wrEn = 1; testEn = 1; testDec = 1; wrData = 16'd20;
    @(posedge clk); #1; idleIn();
    chk("R11 load beats test", 16'd20, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    owrEn = 1; testEn = 1; testDec = 1; wrData = 16'd7;
    @(posedge clk); #1; idleIn();
    chk("R11 overwrite beats test", 16'd7, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    testEn = 1; testDec = 1; popEn = 1;
    @(posedge clk); #1; idleIn();
    chk("R11 test beats pop", 16'd6, 1'b0, 1'b0, 1'b0);
    // R2: idle cycles (read only) leave the count unchanged
    step(3'd0, 16'd0);
    step(3'd0, 16'd0);
    chk("R2 read has no effect", 16'd6, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule